// File: doc/BRIEF.md
# Dual-Channel Prescaled Pulse Generator

This block produces up to two pulse-width modulated outputs from one system clock. Each channel first slows the clock through a divider picked from a fixed table of ratios, or, in builds that allow it, uses the clock directly. The divided ticks drive a period counter. The output sits at its active level for the first part of every period and at the opposite level for the rest. Software sets the block up through a small synchronous register port. One shared control word holds the divider code, run switches and polarity of every channel. Each channel also has its own word that holds the period length and the active length.

A period/duty write goes into a holding copy first. The running waveform takes up the new values only when the current period ends, so a running output never shows a partial period. A per-channel ready flag in the control word reads 1 while such a write is still waiting. A channel that is switched off, or that has an unusable divider code, keeps its counters cleared and parks its output at the inactive level.

Top module: `pwm2_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, every register reads 0. With the active-level bit at 0, each output then sits at its inactive level, which is 1.
- R2: The control word is at byte address 0x0. Channel c owns control bits [15c+6:15c]: the divider code in [15c+3:15c], run-enable at 15c+4, active level at 15c+5 and clock-gate at 15c+6. Its ready flag is read-only at bit 28+c, and all other control bits read 0. The period/duty word of channel c is at 0x4+4c and reads back as last written. Writes to any other address change nothing, and reads of other addresses return 0.
- R3: A channel runs only while its run-enable and clock-gate bits are both 1. Otherwise its output is at the inactive level and its counters are held at zero, so a later start begins at the start of a period.
- R4: In the period/duty word, bits [31:16] hold the period length minus one (P) and bits [15:0] hold the active length (D). A period lasts P+1 divided ticks, and the output is active for the first D of them. D=0 gives a constantly inactive output, and D>P gives a constantly active output.
- R5: When the active-level bit is 1 the active level is high. When it is 0 the waveform is inverted: the active level is low and the inactive level is high.
- R6: Divider codes 0 to 4 divide the clock by 120, 180, 240, 360 and 480. Codes 8 to 12 divide it by 12000, 24000, 36000, 48000 and 72000.
- R7: Codes 5, 6, 7, 13 and 14 are reserved. A channel with a reserved code behaves as switched off.
- R8: With HAS_BYPASS=1, code 15 uses the clock undivided. With HAS_BYPASS=0, code 15 is reserved.
- R9: While a channel runs, a period/duty write is held back and takes effect at the next period boundary. Its ready flag reads 1 from the cycle after the write until that boundary. While a channel is stopped, a write takes effect on the following cycle.
- R10: A control write that changes a channel's divider code restarts that channel's divider count from zero. The period position is kept.
- R11: Channels are independent: setting up or running one channel never changes the other channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte address for both reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pwm_out | output | NUM_CH | One waveform output per channel |

## Verification
Most internal faults show up at the output pins within one period. A divider that counts to the wrong limit moves the first active-to-inactive edge away from the cycle the ratio predicts. A wrong period counter or a wrong duty compare breaks the high/low pattern inside the first period. A bad holding-copy handover is visible in two ways: the ready flag stays stuck or clears too early, or the new duty appears before the boundary cycle. Both are caught within one period of the write. A divider that fails to restart on a code change moves the next edge earlier by the number of ticks already counted. This shows up in the first period after the change.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;
  localparam int REG_W     = 32;
  localparam int DIV_W     = 17;  // holds the largest divider minus one
  localparam int CNT_W     = 16;  // period and duty fields
  localparam int CFG_W     = 7;   // control bits owned by one channel
  localparam int CH_STRIDE = 15;  // distance between channel fields
  localparam int RDY_BASE  = 28;  // first ready flag

  // bit 6 gate, bit 5 active level, bit 4 enable, bits 3:0 divider code
  typedef struct packed {
    logic       gate;
    logic       act;
    logic       en;
    logic [3:0] code;
  } ch_cfg_t;
endpackage

// File: rtl/pwm2_rst_sync.sv
module pwm2_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign srst_n = hold_q;
endmodule

// File: rtl/pwm2_presc_lut.sv
module pwm2_presc_lut
  import pwm2_pkg::*;
#(
  parameter bit HAS_BYPASS = 1'b1
) (
  input  logic [3:0]       code,
  output logic [DIV_W-1:0] div_m1,
  output logic             valid
);
  logic byp_ok;

  generate
    if (HAS_BYPASS) begin : g_byp
      assign byp_ok = 1'b1;
    end else begin : g_nobyp
      assign byp_ok = 1'b0;
    end
  endgenerate

  always_comb begin
    div_m1 = '0;
    valid  = 1'b1;
    case (code)
      4'd0:    div_m1 = DIV_W'(119);
      4'd1:    div_m1 = DIV_W'(179);
      4'd2:    div_m1 = DIV_W'(239);
      4'd3:    div_m1 = DIV_W'(359);
      4'd4:    div_m1 = DIV_W'(479);
      4'd8:    div_m1 = DIV_W'(11999);
      4'd9:    div_m1 = DIV_W'(23999);
      4'd10:   div_m1 = DIV_W'(35999);
      4'd11:   div_m1 = DIV_W'(47999);
      4'd12:   div_m1 = DIV_W'(71999);
      4'd15:   valid  = byp_ok;
      default: valid  = 1'b0;
    endcase
  end
endmodule

// File: rtl/pwm2_channel.sv
module pwm2_channel
  import pwm2_pkg::*;
#(
  parameter bit HAS_BYPASS = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ch_cfg_t          cfg,
  input  logic             code_chg,
  input  logic             pd_wr,
  input  logic [REG_W-1:0] pd_wdata,
  output logic [REG_W-1:0] pd_shadow,
  output logic             pend,
  output logic             pwm_o
);
  logic [DIV_W-1:0] div_m1;
  logic             code_ok;
  logic             run;
  logic             tick;
  logic             wrap;
  logic             load;
  logic             in_duty;

  logic [DIV_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] per_q, per_d;
  logic [CNT_W-1:0] lim_q;
  logic [CNT_W-1:0] dut_q;
  logic [REG_W-1:0] shd_q;
  logic             pend_q, pend_d;

  pwm2_presc_lut #(.HAS_BYPASS(HAS_BYPASS)) i_lut (
    .code   (cfg.code),
    .div_m1 (div_m1),
    .valid  (code_ok)
  );

  assign run  = cfg.en & cfg.gate & code_ok;
  assign tick = run & ~code_chg & (pre_q == div_m1);
  assign wrap = tick & (per_q == lim_q);
  assign load = ~run | wrap;

  always_comb begin
    if (!run || code_chg || tick) pre_d = '0;
    else                          pre_d = pre_q + 1'b1;

    if (!run || wrap) per_d = '0;
    else if (tick)    per_d = per_q + 1'b1;
    else              per_d = per_q;

    if (pd_wr)     pend_d = 1'b1;
    else if (load) pend_d = 1'b0;
    else           pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      per_q  <= '0;
      lim_q  <= '0;
      dut_q  <= '0;
      shd_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      per_q  <= per_d;
      pend_q <= pend_d;
      if (load) begin
        lim_q <= shd_q[REG_W-1:CNT_W];
        dut_q <= shd_q[CNT_W-1:0];
      end
      if (pd_wr) begin
        shd_q <= pd_wdata;
      end
    end
  end

  assign in_duty   = run & (per_q < dut_q);
  assign pwm_o     = in_duty ? cfg.act : ~cfg.act;
  assign pd_shadow = shd_q;
  assign pend      = pend_q;
endmodule

// File: rtl/pwm2_ctrl.sv
module pwm2_ctrl
  import pwm2_pkg::*;
#(
  parameter int NUM_CH     = 2,      // 1 or 2: control word holds two channels
  parameter bit HAS_BYPASS = 1'b1,
  parameter int ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;

  function automatic logic [ADDR_W-1:0] pd_addr(input int ch);
    return ADDR_W'(4 + 4 * ch);
  endfunction

  logic                   rst_n_s;
  logic                   ctrl_wr;
  ch_cfg_t [NUM_CH-1:0]   cfg_q, cfg_d, cfg_nxt;
  logic    [NUM_CH-1:0]   code_chg;
  logic    [NUM_CH-1:0]   pd_wr;
  logic    [NUM_CH-1:0]   pend;
  logic    [REG_W-1:0]    shadow [NUM_CH];

  pwm2_rst_sync i_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_n_s)
  );

  assign ctrl_wr = reg_wr & (reg_addr == CTRL_ADDR);

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      cfg_d[c]    = ch_cfg_t'(reg_wdata[c*CH_STRIDE +: CFG_W]);
      code_chg[c] = ctrl_wr & (cfg_d[c].code != cfg_q[c].code);
      pd_wr[c]    = reg_wr & (reg_addr == pd_addr(c));
    end
    cfg_nxt = ctrl_wr ? cfg_d : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) cfg_q <= '0;
    else          cfg_q <= cfg_nxt;
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      pwm2_channel #(.HAS_BYPASS(HAS_BYPASS)) i_ch (
        .clk       (clk),
        .rst_n     (rst_n_s),
        .cfg       (cfg_q[g]),
        .code_chg  (code_chg[g]),
        .pd_wr     (pd_wr[g]),
        .pd_wdata  (reg_wdata),
        .pd_shadow (shadow[g]),
        .pend      (pend[g]),
        .pwm_o     (pwm_out[g])
      );
    end
  endgenerate

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CTRL_ADDR) begin
      for (int c = 0; c < NUM_CH; c++) begin
        reg_rdata[c*CH_STRIDE +: CFG_W] = cfg_q[c];
        reg_rdata[RDY_BASE + c]         = pend[c];
      end
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (reg_addr == pd_addr(c)) reg_rdata = shadow[c];
    end
  end
endmodule

// File: rtl/pwm2_ctrl_chk.sv
module pwm2_ctrl_chk
  import pwm2_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_wr,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [REG_W-1:0]     reg_rdata,
  input logic [NUM_CH-1:0]    pwm_out,
  input ch_cfg_t [NUM_CH-1:0] cfg_q,
  input logic [NUM_CH-1:0]    pend
);
  function automatic logic [REG_W-1:0] used_bits();
    logic [REG_W-1:0] m;
    m = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      m[c*CH_STRIDE +: CFG_W] = '1;
      m[RDY_BASE + c]         = 1'b1;
    end
    return m;
  endfunction

  localparam logic [REG_W-1:0] USED = used_bits();

  // R2
  ctrl_unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == '0) |-> ((reg_rdata & ~USED) == '0))
    else $error("unused control bits read non-zero");

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
      // R3
      off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_q[g].en && cfg_q[g].gate) |-> (pwm_out[g] == ~cfg_q[g].act))
        else $error("stopped channel not at inactive level");

      // R7
      rsv_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[g].code inside {4'd5, 4'd6, 4'd7, 4'd13, 4'd14})
          |-> (pwm_out[g] == ~cfg_q[g].act))
        else $error("reserved code channel not idle");

      // R9
      pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(4 + 4 * g)) |=> pend[g])
        else $error("ready flag not set after period write");
    end
  endgenerate
endmodule

bind pwm2_ctrl pwm2_ctrl_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_pwm2_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .pwm_out   (pwm_out),
  .cfg_q     (cfg_q),
  .pend      (pend)
);

// File: tb/test_pwm2_ctrl.sv
`timescale 1ns/1ps
module test_pwm2_ctrl;
  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [1:0]  pwm_out;

  logic        nb_wr;
  logic [3:0]  nb_addr;
  logic [31:0] nb_wdata;
  logic [31:0] nb_rdata;
  logic [0:0]  nb_out;

  int total = 0;
  int passed = 0;
  bit done = 0;

  pwm2_ctrl #(.NUM_CH(2), .HAS_BYPASS(1'b1), .ADDR_W(4)) i_pwm2_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out));

  pwm2_ctrl #(.NUM_CH(1), .HAS_BYPASS(1'b0), .ADDR_W(4)) i_pwm2_ctrl_nobyp (
    .clk(clk), .rst_n(rst_n), .reg_wr(nb_wr), .reg_addr(nb_addr),
    .reg_wdata(nb_wdata), .reg_rdata(nb_rdata), .pwm_out(nb_out));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [3:0]  code;
    logic [15:0] per;
    logic [15:0] dut;
    logic        act;
    logic [31:0] ncyc;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{4'd15, 16'd4, 16'd2, 1'b1, 32'd20},     // R4 R8 bypass
    '{4'd15, 16'd4, 16'd0, 1'b1, 32'd20},     // R4 duty zero
    '{4'd15, 16'd3, 16'd9, 1'b1, 32'd20},     // R4 duty above period
    '{4'd15, 16'd5, 16'd3, 1'b0, 32'd24},     // R5 inverted
    '{4'd0,  16'd2, 16'd1, 1'b1, 32'd720},    // R6 /120
    '{4'd2,  16'd1, 16'd1, 1'b1, 32'd960},    // R6 /240
    '{4'd4,  16'd1, 16'd1, 1'b0, 32'd1920},   // R6 /480 inverted
    '{4'd8,  16'd1, 16'd1, 1'b1, 32'd26000},  // R6 /12000
    '{4'd12, 16'd0, 16'd0, 1'b0, 32'd100}     // R6 /72000 duty zero
  };

  function automatic int unsigned bench_div(input logic [3:0] code);
    case (code)
      4'd0: return 120;     4'd1: return 180;     4'd2: return 240;
      4'd3: return 360;     4'd4: return 480;     4'd8: return 12000;
      4'd9: return 24000;   4'd10: return 36000;  4'd11: return 48000;
      4'd12: return 72000;  4'd15: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic exp_level(input int unsigned n, input int unsigned dv,
                                     input logic [15:0] per, input logic [15:0] dut,
                                     input logic act);
    int unsigned pos;
    pos = (n / dv) % (int'(per) + 1);
    return (pos < int'(dut)) ? act : ~act;
  endfunction

  function automatic logic [31:0] cw(input int ch, input logic [3:0] code,
                                     input logic en, input logic act, input logic gate);
    logic [31:0] w;
    w = {25'd0, gate, act, en, code};
    return w << (ch * 15);
  endfunction

  task automatic chk(input logic ok, input string req,
                     input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (ok) passed++;
    else $display("FAIL %s: got %0h expected %0h", req, got, exp);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic nb_write(input logic [3:0] a, input logic [31:0] d);
    nb_wr = 1'b1; nb_addr = a; nb_wdata = d;
    @(negedge clk);
    nb_wr = 1'b0;
  endtask

  initial begin
    #600000;
    if (!done) begin
      total++;
      $display("FAIL R4 watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", passed, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    nb_wr = 1'b0; nb_addr = '0; nb_wdata = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    rd(4'h0, d);
    chk(pwm_out == 2'b11 && d == 32'h0, "R1 reset outputs", {30'd0, pwm_out}, 32'h3);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(4'h0, d); chk(d == 32'h0, "R1 ctrl after reset", d, 32'h0);
    rd(4'h4, d); chk(d == 32'h0, "R1 pd0 after reset", d, 32'h0);
    rd(4'h8, d); chk(d == 32'h0, "R1 pd1 after reset", d, 32'h0);
    @(negedge clk);

    // Vector table walk on channel 0, channel 1 stays off (R11)
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      int unsigned dv;
      bit ok;
      logic got_b, exp_b;
      v = VECS[i];
      dv = bench_div(v.code);
      ok = 1'b1; got_b = 1'b0; exp_b = 1'b0;
      wr(4'h0, 32'h0);
      wr(4'h4, {v.per, v.dut});
      wr(4'h0, cw(0, v.code, 1'b1, v.act, 1'b1));
      for (int n = 0; n < int'(v.ncyc); n++) begin
        logic e;
        e = exp_level(n, dv, v.per, v.dut, v.act);
        if (ok && (pwm_out[0] !== e || pwm_out[1] !== 1'b1)) begin
          ok = 1'b0; got_b = pwm_out[0]; exp_b = e;
        end
        @(negedge clk);
      end
      chk(ok, $sformatf("R4 R5 R6 R11 vector %0d", i), {31'd0, got_b}, {31'd0, exp_b});
    end

    // R2 register map and ignored addresses
    wr(4'h0, 32'h0);
    wr(4'h4, 32'h0003_0005);
    wr(4'h8, 32'hABCD_1234);
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'h8, d); chk(d == 32'hABCD_1234, "R2 pd1 readback", d, 32'hABCD_1234);
    rd(4'hC, d); chk(d == 32'h0, "R2 unmapped read", d, 32'h0);
    rd(4'h4, d); chk(d == 32'h0003_0005, "R2 unmapped write ignored pd0", d, 32'h0003_0005);
    rd(4'h0, d); chk(d == 32'h0, "R2 unmapped write ignored ctrl", d, 32'h0);
    @(negedge clk);
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, d); chk(d == 32'h003F_807F, "R2 ctrl field layout", d, 32'h003F_807F);
    @(negedge clk);
    wr(4'h0, 32'h0);

    // R3 both enable and gate needed (pd0 = P3 D5, always active when running)
    wr(4'h0, cw(0, 4'd15, 1'b1, 1'b1, 1'b0));
    repeat (4) @(negedge clk);
    chk(pwm_out[0] == 1'b0, "R3 enable without gate", {31'd0, pwm_out[0]}, 32'h0);
    wr(4'h0, cw(0, 4'd15, 1'b0, 1'b1, 1'b1));
    repeat (4) @(negedge clk);
    chk(pwm_out[0] == 1'b0, "R3 gate without enable", {31'd0, pwm_out[0]}, 32'h0);
    wr(4'h0, cw(0, 4'd15, 1'b1, 1'b1, 1'b1));
    chk(pwm_out[0] == 1'b1, "R3 both set runs", {31'd0, pwm_out[0]}, 32'h1);

    // R7 reserved codes
    wr(4'h0, cw(0, 4'd6, 1'b1, 1'b1, 1'b1));
    repeat (3) @(negedge clk);
    chk(pwm_out[0] == 1'b0, "R7 code 6 idle", {31'd0, pwm_out[0]}, 32'h0);
    wr(4'h0, cw(0, 4'd13, 1'b1, 1'b1, 1'b1));
    repeat (3) @(negedge clk);
    chk(pwm_out[0] == 1'b0, "R7 code 13 idle", {31'd0, pwm_out[0]}, 32'h0);
    wr(4'h0, 32'h0);

    // R9 held update with ready flag at bit 28
    wr(4'h4, {16'd9, 16'd0});
    wr(4'h0, cw(0, 4'd15, 1'b1, 1'b1, 1'b1));
    repeat (3) @(negedge clk);
    wr(4'h4, {16'd9, 16'd10});
    rd(4'h0, d);
    chk(d[28] == 1'b1 && pwm_out[0] == 1'b0, "R9 pending after write",
        {d[28], 30'd0, pwm_out[0]}, 32'h8000_0000);
    repeat (5) @(negedge clk);
    rd(4'h0, d);
    chk(d[28] == 1'b1 && pwm_out[0] == 1'b0, "R9 held until boundary",
        {d[28], 30'd0, pwm_out[0]}, 32'h8000_0000);
    @(negedge clk);
    rd(4'h0, d);
    chk(d[28] == 1'b0 && pwm_out[0] == 1'b1, "R9 applied at boundary",
        {d[28], 30'd0, pwm_out[0]}, 32'h1);
    @(negedge clk);
    wr(4'h0, 32'h0);

    // R10 divider restart on code change, channel 1; R11 channel 0 untouched
    wr(4'h8, {16'd1, 16'd1});
    wr(4'h0, cw(1, 4'd0, 1'b1, 1'b1, 1'b1));
    repeat (100) @(negedge clk);
    wr(4'h0, cw(1, 4'd1, 1'b1, 1'b1, 1'b1));
    repeat (179) @(negedge clk);
    chk(pwm_out[1] == 1'b1, "R10 still active after restart", {31'd0, pwm_out[1]}, 32'h1);
    @(negedge clk);
    chk(pwm_out[1] == 1'b0, "R10 first tick after 180 cycles", {31'd0, pwm_out[1]}, 32'h0);
    chk(pwm_out[0] == 1'b1, "R11 channel 0 unaffected", {31'd0, pwm_out[0]}, 32'h1);
    wr(4'h0, 32'h0);

    // R8 code 15 reserved without bypass
    nb_write(4'h4, {16'd3, 16'd5});
    nb_write(4'h0, cw(0, 4'd15, 1'b1, 1'b1, 1'b1));
    repeat (3) @(negedge clk);
    chk(nb_out[0] == 1'b0, "R8 no-bypass code 15 idle", {31'd0, nb_out[0]}, 32'h0);
    nb_write(4'h0, cw(0, 4'd0, 1'b1, 1'b1, 1'b1));
    chk(nb_out[0] == 1'b1, "R8 no-bypass code 0 runs", {31'd0, nb_out[0]}, 32'h1);

    done = 1;
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule